// File: doc/BRIEF.md
# Receive Character Queue with Error Status and Overrun Holding

This block buffers characters coming out of a serial receiver until a host reads them. Each stored character keeps three error flags: parity, framing and break. These flags leave the queue together with their character. The host sees the oldest character at a combinational read port. It sees a set of status flags, reported either for the front character alone or as an accumulation over every character that has reached the front since the last error clear. Only a data pop advances the queue. Observing the status outputs never changes them.

A character that arrives while the queue is at capacity is kept in a one-entry holding stage. It enters the queue in the same cycle that the host frees a slot. If a further character arrives while the holding stage is occupied, it replaces the held one and the queue itself is untouched. The receiver's start-of-character strobe raises a sticky overrun flag when it appears while a character is already held. The same strobe drives an optional active-low request-to-send line that stops the remote sender while the queue is at capacity.

Top module: `rx_char_queue`

## Requirements
- R1: With `deep_i`=0 the capacity is 8 characters, and with `deep_i`=1 it is 16. `rdy_o` is 1 while at least one character is queued. `full_o` is 1 exactly when the queued count equals the capacity.
- R2: Characters leave in arrival order. `top_data_o` shows the oldest queued character and reads 0 while the queue is empty. A pop (`pop_i`) removes that character in the cycle it is sampled.
- R3: With `block_mode_i`=0 the outputs `pe_o`, `fe_o` and `brk_o` equal the parity, framing and break flags that were pushed with the front character. All three are 0 while the queue is empty.
- R4: With `block_mode_i`=1 each error output is the OR of that flag across every character that has been at the front since the last error clear. The character currently at the front is included.
- R5: An error clear (`err_clr_i`) clears the block-mode accumulation and the overrun flag on the next edge. It leaves the queued characters, their order and `rdy_o` unchanged.
- R6: A push while the queue is full and nothing is held goes into the holding stage, and the queue is left unchanged. On the next pop the held character enters the queue in the same cycle, so `full_o` stays 1.
- R7: A push while a character is already held replaces the held character, which is lost. The queue contents are unchanged.
- R8: `start_seen_i` while a character is held, with no pop in that cycle, sets `ovr_o` on the next edge. `ovr_o` stays set until an error clear or a receiver reset.
- R9: With `rts_en_i`=1, `rts_n_o` goes to 1 on the edge after `start_seen_i` is sampled while `full_o`=1. It returns to 0 on the edge after any cycle in which `full_o`=0. With `rts_en_i`=0 it is 0.
- R10: A receiver reset (`rx_reset_i`) empties the queue and discards any held character. It clears the accumulation and `ovr_o` and drives `rts_n_o` to 0, all on the next edge.
- R11: A push and a pop in the same cycle, on a queue that is neither empty nor full, keep the count unchanged. A pop on an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Receiver delivers one character |
| push_data_i | input | 8 | Delivered character |
| push_pe_i | input | 1 | Parity error flag of the delivered character |
| push_fe_i | input | 1 | Framing error flag of the delivered character |
| push_brk_i | input | 1 | Break flag of the delivered character |
| start_seen_i | input | 1 | Receiver has accepted a start bit |
| pop_i | input | 1 | Host takes the front character |
| err_clr_i | input | 1 | Clear the error accumulation and overrun |
| rx_reset_i | input | 1 | Synchronous receiver reset |
| deep_i | input | 1 | Capacity select: 0 = 8, 1 = 16 |
| block_mode_i | input | 1 | 0 = per-character status, 1 = accumulated status |
| rts_en_i | input | 1 | Enable automatic request-to-send control |
| top_data_o | output | 8 | Front character, 0 when empty |
| rdy_o | output | 1 | At least one character queued |
| full_o | output | 1 | Queue at selected capacity |
| pe_o | output | 1 | Parity error status |
| fe_o | output | 1 | Framing error status |
| brk_o | output | 1 | Break status |
| ovr_o | output | 1 | Overrun status |
| rts_n_o | output | 1 | Active-low request-to-send |

## Verification
The following properties are checked on every cycle:
- `full_o` implies `rdy_o`.
- In character mode an empty queue reports clean status and zero data.
- A pop that moves the held character in keeps the queue full.
- Overrun is set and then stays set.
- The request-to-send line rises and falls one edge after its causes.
- Receiver reset and error clear take effect on the next edge.
- The front character holds still while nothing is pushed or popped.

Only the bench scenarios can show the following:
- Arrival order across a full fill and drain at both capacities.
- Flags staying attached to their own characters.
- The exact OR accumulated in block mode.
- Which of two characters survives in the holding stage.
- That an error clear leaves the queue contents alone.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  rxq_flags_t    wr_flags,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output rxq_flags_t    rd_flags
);
  logic [DW-1:0] data_mem  [DEPTH];
  rxq_flags_t    flags_mem [DEPTH];

  // Storage carries no reset; occupancy is tracked by the controller.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_addr]  <= wr_data;
      flags_mem[wr_addr] <= wr_flags;
    end
  end

  assign rd_data  = data_mem[rd_addr];
  assign rd_flags = flags_mem[rd_addr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  rxq_flags_t    push_flags_i,
  input  logic          pop_i,
  input  logic          rx_reset_i,
  input  logic          deep_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output rxq_flags_t    wr_flags_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rdy_o,
  output logic          full_o,
  output logic          pop_ok_o,
  output logic          hold_vld_o
);
  localparam logic [CW-1:0] CAP_DEEP    = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_SHALLOW = CW'(DEPTH / 2);

  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n, cap;
  logic          hold_q, hold_n;
  logic          hold_ld;
  logic          from_hold;
  logic [DW-1:0] hold_data_q;
  rxq_flags_t    hold_flags_q;

  assign cap    = deep_i ? CAP_DEEP : CAP_SHALLOW;
  assign rdy_o  = (cnt_q != '0);
  assign full_o = (cnt_q >= cap);

  always_comb begin
    pop_ok_o  = pop_i && rdy_o;
    wr_en_o   = 1'b0;
    from_hold = 1'b0;
    hold_n    = hold_q;
    hold_ld   = 1'b0;
    if (hold_q) begin
      if (pop_ok_o) begin
        // The held character fills the slot freed by this pop.
        wr_en_o   = 1'b1;
        from_hold = 1'b1;
        hold_n    = push_i;
        hold_ld   = push_i;
      end else if (push_i) begin
        // The newer character takes the holding stage; the older one is lost.
        hold_ld = 1'b1;
      end
    end else if (push_i) begin
      if (!full_o || pop_ok_o) begin
        wr_en_o = 1'b1;
      end else begin
        hold_n  = 1'b1;
        hold_ld = 1'b1;
      end
    end
    if (rx_reset_i) begin
      pop_ok_o = 1'b0;
      wr_en_o  = 1'b0;
      hold_n   = 1'b0;
      hold_ld  = 1'b0;
    end
    wr_n  = rx_reset_i ? '0 : wr_q + AW'(wr_en_o);
    rd_n  = rx_reset_i ? '0 : rd_q + AW'(pop_ok_o);
    cnt_n = rx_reset_i ? '0 : cnt_q + CW'(wr_en_o) - CW'(pop_ok_o);
  end

  assign wr_addr_o  = wr_q;
  assign rd_addr_o  = rd_q;
  assign wr_data_o  = from_hold ? hold_data_q  : push_data_i;
  assign wr_flags_o = from_hold ? hold_flags_q : push_flags_i;
  assign hold_vld_o = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
      hold_q <= hold_n;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_ld) begin
      hold_data_q  <= push_data_i;
      hold_flags_q <= push_flags_i;
    end
  end
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_reset_i,
  input  logic       err_clr_i,
  input  logic       block_mode_i,
  input  logic       rts_en_i,
  input  logic       start_seen_i,
  input  logic       rdy_i,
  input  logic       full_i,
  input  logic       hold_vld_i,
  input  logic       pop_ok_i,
  input  rxq_flags_t top_flags_i,
  output rxq_flags_t flags_o,
  output logic       ovr_o,
  output logic       rts_n_o
);
  rxq_flags_t acc_q, acc_n, top_g;
  logic       ovr_q, ovr_n;
  logic       rts_q, rts_n;

  assign top_g = rdy_i ? top_flags_i : '0;

  always_comb begin
    acc_n = acc_q | top_g;
    if (rx_reset_i || err_clr_i) acc_n = '0;

    ovr_n = ovr_q;
    if (start_seen_i && hold_vld_i && !pop_ok_i) ovr_n = 1'b1;
    if (rx_reset_i || err_clr_i)                 ovr_n = 1'b0;

    rts_n = rts_q;
    if (rx_reset_i || !rts_en_i)       rts_n = 1'b0;
    else if (start_seen_i && full_i)   rts_n = 1'b1;
    else if (!full_i)                  rts_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
      rts_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      ovr_q <= ovr_n;
      rts_q <= rts_n;
    end
  end

  assign flags_o = block_mode_i ? (acc_q | top_g) : top_g;
  assign ovr_o   = ovr_q;
  assign rts_n_o = rts_q;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_pe_i,
  input  logic          push_fe_i,
  input  logic          push_brk_i,
  input  logic          start_seen_i,
  input  logic          pop_i,
  input  logic          err_clr_i,
  input  logic          rx_reset_i,
  input  logic          deep_i,
  input  logic          block_mode_i,
  input  logic          rts_en_i,
  output logic [DW-1:0] top_data_o,
  output logic          rdy_o,
  output logic          full_o,
  output logic          pe_o,
  output logic          fe_o,
  output logic          brk_o,
  output logic          ovr_o,
  output logic          rts_n_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  rxq_flags_t    push_flags, wr_flags, rd_flags, stat_flags;
  logic          wr_en, pop_ok, hold_vld;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  assign push_flags = '{brk: push_brk_i, fe: push_fe_i, pe: push_pe_i};

  rxq_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .push_flags_i(push_flags),
    .pop_i       (pop_i),
    .rx_reset_i  (rx_reset_i),
    .deep_i      (deep_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_flags_o  (wr_flags),
    .rd_addr_o   (rd_addr),
    .rdy_o       (rdy_o),
    .full_o      (full_o),
    .pop_ok_o    (pop_ok),
    .hold_vld_o  (hold_vld)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_flags(wr_flags),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_flags(rd_flags)
  );

  rxq_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_reset_i  (rx_reset_i),
    .err_clr_i   (err_clr_i),
    .block_mode_i(block_mode_i),
    .rts_en_i    (rts_en_i),
    .start_seen_i(start_seen_i),
    .rdy_i       (rdy_o),
    .full_i      (full_o),
    .hold_vld_i  (hold_vld),
    .pop_ok_i    (pop_ok),
    .top_flags_i (rd_flags),
    .flags_o     (stat_flags),
    .ovr_o       (ovr_o),
    .rts_n_o     (rts_n_o)
  );

  assign top_data_o = rdy_o ? rd_data : '0;
  assign pe_o       = stat_flags.pe;
  assign fe_o       = stat_flags.fe;
  assign brk_o      = stat_flags.brk;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic          start_seen_i,
  input logic          err_clr_i,
  input logic          rx_reset_i,
  input logic          deep_i,
  input logic          block_mode_i,
  input logic          rts_en_i,
  input logic [DW-1:0] top_data_o,
  input logic          rdy_o,
  input logic          full_o,
  input logic          pe_o,
  input logic          fe_o,
  input logic          brk_o,
  input logic          ovr_o,
  input logic          rts_n_o,
  input logic          hold_vld
);
  assert_full_has_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> rdy_o);

  // R2 and R3: an empty queue in character mode shows zero data and clean flags.
  assert_empty_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_mode_i && !rdy_o) |-> (!pe_o && !fe_o && !brk_o && top_data_o == '0));

  assert_front_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i && !rx_reset_i) |=> $stable(top_data_o));

  assert_errclr_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !rx_reset_i) |=> !ovr_o);

  assert_hold_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && full_o && pop_i && !rx_reset_i) |=> (full_o || !$stable(deep_i)));

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen_i && hold_vld && !pop_i && !rx_reset_i && !err_clr_i) |=> ovr_o);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !rx_reset_i && !err_clr_i) |=> ovr_o);

  assert_rts_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en_i && start_seen_i && full_o && !rx_reset_i) |=> rts_n_o);

  assert_rts_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_o || !rts_en_i) |=> !rts_n_o);

  assert_rx_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset_i |=> (!rdy_o && !ovr_o && !rts_n_o && !full_o));
endmodule

bind rx_char_queue rxq_checker #(.DW(DW)) u_rxq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .start_seen_i(start_seen_i),
  .err_clr_i   (err_clr_i),
  .rx_reset_i  (rx_reset_i),
  .deep_i      (deep_i),
  .block_mode_i(block_mode_i),
  .rts_en_i    (rts_en_i),
  .top_data_o  (top_data_o),
  .rdy_o       (rdy_o),
  .full_o      (full_o),
  .pe_o        (pe_o),
  .fe_o        (fe_o),
  .brk_o       (brk_o),
  .ovr_o       (ovr_o),
  .rts_n_o     (rts_n_o),
  .hold_vld    (hold_vld)
);

// File: tb/tb_rx_char_queue.sv
module tb_rx_char_queue;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       push_i, push_pe_i, push_fe_i, push_brk_i;
  logic [7:0] push_data_i;
  logic       start_seen_i, pop_i, err_clr_i, rx_reset_i;
  logic       deep_i, block_mode_i, rts_en_i;
  logic [7:0] top_data_o;
  logic       rdy_o, full_o, pe_o, fe_o, brk_o, ovr_o, rts_n_o;

  int n_chk;
  int n_fail;
  bit done;

  rx_char_queue #(.DW(8), .DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .push_data_i(push_data_i),
    .push_pe_i(push_pe_i), .push_fe_i(push_fe_i), .push_brk_i(push_brk_i),
    .start_seen_i(start_seen_i), .pop_i(pop_i), .err_clr_i(err_clr_i),
    .rx_reset_i(rx_reset_i), .deep_i(deep_i), .block_mode_i(block_mode_i),
    .rts_en_i(rts_en_i),
    .top_data_o(top_data_o), .rdy_o(rdy_o), .full_o(full_o),
    .pe_o(pe_o), .fe_o(fe_o), .brk_o(brk_o), .ovr_o(ovr_o), .rts_n_o(rts_n_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] dval(int i, int d);
    return 8'((i * 29 + d * 7 + 3) & 8'hFF);
  endfunction

  function automatic logic [2:0] fval(int i);
    return 3'((i * 3 + 1) % 8);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    push_i = 1'b0; pop_i = 1'b0; start_seen_i = 1'b0;
    err_clr_i = 1'b0; rx_reset_i = 1'b0;
  endtask

  task automatic push(logic [7:0] d, logic [2:0] f);
    push_i = 1'b1; push_data_i = d;
    push_pe_i = f[0]; push_fe_i = f[1]; push_brk_i = f[2];
  endtask

  function automatic logic [2:0] flags_now();
    return {brk_o, fe_o, pe_o};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    push_i = 0; push_data_i = 0; push_pe_i = 0; push_fe_i = 0; push_brk_i = 0;
    start_seen_i = 0; pop_i = 0; err_clr_i = 0; rx_reset_i = 0;
    deep_i = 0; block_mode_i = 0; rts_en_i = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R10 reset rdy", 32'(rdy_o), 0);
    check("R10 reset rts", 32'(rts_n_o), 0);

    for (int d = 0; d < 2; d++) begin
      int cap;
      logic [2:0] acc;
      cap = (d == 1) ? 16 : 8;
      deep_i = d[0]; block_mode_i = d[0]; rts_en_i = 1'b1;
      rx_reset_i = 1'b1; tick();
      check("R10 rdy", 32'(rdy_o), 0);
      check("R10 full", 32'(full_o), 0);
      check("R10 ovr", 32'(ovr_o), 0);
      check("R10 top", 32'(top_data_o), 0);

      // R1: fill to the selected capacity
      for (int i = 0; i < cap; i++) begin
        push(dval(i, d), fval(i)); tick();
        check("R1 rdy", 32'(rdy_o), 1);
        check("R1 full", 32'(full_o), (i == cap - 1) ? 1 : 0);
        check("R2 front", 32'(top_data_o), 32'(dval(0, d)));
      end

      start_seen_i = 1'b1; tick();
      check("R9 rts raised", 32'(rts_n_o), 1);
      check("R8 no ovr", 32'(ovr_o), 0);

      push(8'hA5, 3'b101); tick();
      check("R6 full", 32'(full_o), 1);
      check("R6 front", 32'(top_data_o), 32'(dval(0, d)));
      check("R6 no ovr", 32'(ovr_o), 0);

      start_seen_i = 1'b1; tick();
      check("R8 ovr set", 32'(ovr_o), 1);

      push(8'h5A, 3'b010); tick();
      check("R7 front", 32'(top_data_o), 32'(dval(0, d)));
      check("R7 full", 32'(full_o), 1);

      if (d == 1) begin
        err_clr_i = 1'b1; tick();
        check("R5 ovr cleared", 32'(ovr_o), 0);
        check("R5 front", 32'(top_data_o), 32'(dval(0, d)));
      end

      acc = 3'b000;
      for (int k = 0; k <= cap; k++) begin
        logic [7:0] ed;
        logic [2:0] ef;
        ed = (k < cap) ? dval(k, d) : 8'h5A;
        ef = (k < cap) ? fval(k) : 3'b010;
        acc = acc | ef;
        check("R2 order", 32'(top_data_o), 32'(ed));
        if (d == 1) check("R4 accumulated", 32'(flags_now()), 32'(acc));
        else        check("R3 per character", 32'(flags_now()), 32'(ef));
        pop_i = 1'b1; tick();
        if (k == 0) begin
          check("R6 refill keeps full", 32'(full_o), 1);
          check("R9 rts held", 32'(rts_n_o), 1);
        end
      end
      check("R2 drained", 32'(rdy_o), 0);
      check("R2 empty data", 32'(top_data_o), 0);
      tick();
      check("R9 rts released", 32'(rts_n_o), 0);
      check("R4 empty flags", 32'(flags_now()), (d == 1) ? 32'(acc) : 0);
      check("R8 sticky", 32'(ovr_o), (d == 1) ? 0 : 1);

      err_clr_i = 1'b1; tick();
      check("R5 flags cleared", 32'(flags_now()), 0);
      check("R5 ovr cleared", 32'(ovr_o), 0);

      push(8'h11, 3'b001); tick();
      push(8'h22, 3'b110); tick();
      err_clr_i = 1'b1; tick();
      check("R5 contents kept", 32'(top_data_o), 32'h11);
      check("R5 rdy kept", 32'(rdy_o), 1);
      check("R5 front flags", 32'(flags_now()), 32'h1);

      push(8'h33, 3'b000); pop_i = 1'b1; tick();
      check("R11 simultaneous", 32'(top_data_o), 32'h22);
      pop_i = 1'b1; tick();
      check("R11 third", 32'(top_data_o), 32'h33);
      pop_i = 1'b1; tick();
      check("R11 empty", 32'(rdy_o), 0);
      pop_i = 1'b1; tick();
      check("R11 empty pop ignored", 32'(rdy_o), 0);
      push(8'h44, 3'b000); tick();
      check("R11 after empty pop", 32'(top_data_o), 32'h44);
      check("R11 single", 32'(full_o), 0);

      rts_en_i = 1'b0;
      for (int i = 1; i < cap; i++) begin
        push(8'(i), 3'b000); tick();
      end
      check("R1 refilled", 32'(full_o), 1);
      start_seen_i = 1'b1; tick();
      check("R9 disabled", 32'(rts_n_o), 0);
      rx_reset_i = 1'b1; tick();
      check("R10 rdy after fill", 32'(rdy_o), 0);
      check("R10 top after fill", 32'(top_data_o), 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule